// File: doc/BRIEF.md
# Mixed-Radix BCD Stopwatch Core

This core measures elapsed time as a chain of BCD digits. A prescaler divides the system clock down to a 10 ms tick. Each tick advances the least significant digit. Every digit wraps at its own modulus and carries into the digit above it. With the default moduli of 10, 10, 10, 6, 10 and 6 (least significant first), the chain shows hundredths, tenths, seconds, tens of seconds, minutes and tens of minutes.

A one-cycle `start` pulse switches the core between running and paused. The pulse is expected to come from an external debounced push-button and edge detector. A synchronous reset clears everything. The digit vector and a per-digit decimal-point mask go to an external display driver.

Top module: `bcd_stopwatch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the run flag, the prescaler and every digit are cleared to zero, so `digits_o` reads all zeros after that edge. The reset dominates `start`.
- R2: A `start` pulse sampled high at an edge toggles the run flag at that edge. While the flag is clear, the prescaler and all digits hold their values.
- R3: While running, the prescaler issues one tick every DIV clock cycles, where DIV = TICK_NS / CLK_PERIOD_NS. The defaults of 10,000,000 ns and 10 ns give DIV = 1,000,000. The first tick falls DIV edges after the edge that set the run flag.
- R4: Digit 0 (`digits_o[3:0]`) increments by one on each tick and wraps to zero after reaching its modulus minus one.
- R5: Digit i (`digits_o[4*i+3:4*i]`) changes on a tick only when every lower digit sits at its maximum. The carry ripples through all digits within the same clock edge.
- R6: No digit ever exceeds its modulus minus one. A modulus-6 digit steps 5→0, and a modulus-10 digit steps 9→0.
- R7: When all digits sit at their maxima and a tick occurs, the count rolls over to all zeros and keeps running.
- R8: Bit i of `dots_o` always equals bit i of the DOT_MASK parameter. It has no influence on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that toggles run/pause |
| digits_o | output | 4*NUM_DIGITS | BCD digit values; digit i occupies bits 4*i+3..4*i |
| dots_o | output | NUM_DIGITS | Per-digit decimal-point flags for the display |

## Verification
The run flag changes on the same edge that samples `start`. The first tick, and so the first change of digit 0, lands DIV edges later. Every carry lands on the very edge of the tick that causes it. A reset is visible right after the edge that samples it. The bench keeps a behavioural reference model that it updates on each rising edge from the inputs alone, and it compares every output at the following falling edge, away from the active edge. A separate check counts the edges from the start pulse to the first digit change to confirm the DIV latency. The bench uses a small divisor and small moduli, so that both 9→0 and 5→0 carries and several full rollovers fit into the run.

// File: rtl/sw_pkg.sv
// Package: shared widths and types for the stopwatch core.
// Assumes every modulus fits a 4-bit BCD digit (2..10).
package sw_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/sw_tick_gen.sv
// Module: sw_tick_gen
// Divides the clock to one tick every DIV cycles while `run` is high.
// Assumes DIV >= 2. The count freezes while paused and clears on reset.
module sw_tick_gen #(
    parameter int DIV = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Advance the divide counter only while running; wrap at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // A tick is the running cycle in which the counter sits at LAST.
    always_comb tick = run && (cnt == LAST);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_hold_paused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
    assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == '0);
endmodule

// File: rtl/sw_run_ctl.sv
// Module: sw_run_ctl
// Holds the run/pause flag and toggles it on each start pulse.
// Assumes `start` is a single-cycle pulse produced outside the core.
module sw_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run
);
    // Toggle on start; reset forces paused.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (start)
            run <= ~run;
    end

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> run != $past(run));
    assert_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> run == $past(run));
endmodule

// File: rtl/sw_digit.sv
// Module: sw_digit
// One BCD digit that counts modulo MOD when `inc` is high.
// Assumes 2 <= MOD <= 10. `at_max` flags value MOD-1 for the carry chain.
module sw_digit
    import sw_pkg::*;
#(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output bcd_t value,
    output logic at_max
);
    localparam bcd_t TOP = bcd_t'(MOD - 1);

    // Step the digit on inc, wrapping from TOP back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (inc)
            value <= (value == TOP) ? '0 : value + 1'b1;
    end

    // Flag the maximum so the next digit up may carry.
    always_comb at_max = (value == TOP);

    assert_digit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        value <= TOP);
    assert_digit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(value));
    assert_digit_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc && value == TOP |=> value == '0);
    assert_digit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inc && value != TOP |=> value == $past(value) + 1'b1);
endmodule

// File: rtl/bcd_stopwatch.sv
// Module: bcd_stopwatch
// Stopwatch core: prescaler, run/pause flag and a mixed-radix BCD chain.
// Assumes start is already debounced and edge-detected. Digit i uses
// MODULI[4*i+3:4*i] as its modulus; digit 0 is the least significant.
module bcd_stopwatch
    import sw_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int TICK_NS       = 10000000,
    parameter int NUM_DIGITS    = 6,
    parameter logic [4*NUM_DIGITS-1:0] MODULI = {4'd6, 4'd10, 4'd6, 4'd10, 4'd10, 4'd10},
    parameter logic [NUM_DIGITS-1:0]   DOT_MASK = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic [4*NUM_DIGITS-1:0] digits_o,
    output logic [NUM_DIGITS-1:0]   dots_o
);
    localparam int DIV = TICK_NS / CLK_PERIOD_NS;

    logic                  run;
    logic                  tick;
    logic [NUM_DIGITS:0]   carry;
    logic [NUM_DIGITS-1:0] at_max;

    sw_run_ctl u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (run)
    );

    sw_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // Feed the tick into the bottom of the carry chain.
    always_comb carry[0] = tick;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        bcd_t val;
        sw_digit #(.MOD(int'(MODULI[4*i +: 4]))) u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (carry[i]),
            .value  (val),
            .at_max (at_max[i])
        );
        // Ripple the carry upward within the same cycle.
        always_comb carry[i+1] = carry[i] & at_max[i];
        // Place this digit into the output vector.
        always_comb digits_o[4*i +: 4] = val;
    end

    // Hand the decimal-point flags straight to the display.
    always_comb dots_o = DOT_MASK;

    assert_rollover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry[NUM_DIGITS] |=> digits_o == '0);
    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(digits_o));
endmodule

// File: tb/bcd_stopwatch_test.sv
// Bench: behavioural reference model compared on every falling edge.
module bcd_stopwatch_test;
    localparam int N    = 6;
    localparam int CPN  = 5;
    localparam int TNS  = 10;
    localparam int DIV  = TNS / CPN;
    localparam logic [4*N-1:0] MODS = {4'd2, 4'd10, 4'd3, 4'd6, 4'd2, 4'd10};
    localparam logic [N-1:0]   DOTS = 6'b010100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4*N-1:0] digits_o;
    logic [N-1:0]   dots_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int rollovers = 0;

    // Reference state.
    int  m_run = 0;
    int  m_cnt = 0;
    int  m_d[N];

    always #2.5 clk = ~clk;

    bcd_stopwatch #(
        .CLK_PERIOD_NS(CPN), .TICK_NS(TNS), .NUM_DIGITS(N),
        .MODULI(MODS), .DOT_MASK(DOTS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .digits_o(digits_o), .dots_o(dots_o)
    );

    function automatic int modof(int i);
        return int'(MODS[4*i +: 4]);
    endfunction

    // Advance the reference model from the sampled inputs only.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) m_d[i] = 0;
        end else begin
            bit tk;
            tk = (m_run != 0) && (m_cnt == DIV - 1);
            if (m_run != 0) m_cnt = tk ? 0 : m_cnt + 1;
            if (tk) begin
                bit cy;
                cy = 1'b1;
                for (int i = 0; i < N; i++) begin
                    if (cy) begin
                        if (m_d[i] == modof(i) - 1) m_d[i] = 0;
                        else begin m_d[i] = m_d[i] + 1; cy = 1'b0; end
                    end
                end
                if (cy) rollovers++;
            end
            if (start) m_run = (m_run != 0) ? 0 : 1;
        end
    end

    // Compare every output against the model on the falling edge.
    always @(negedge clk) begin
        vectors++;
        for (int i = 0; i < N; i++) begin
            int act;
            act = int'(digits_o[4*i +: 4]);
            if (act != m_d[i]) begin
                errors++;
                $display("FAIL %s digit %0d: actual %0d expected %0d at cycle %0d",
                         (!rst_n) ? "R1" : (i == 0) ? "R4" : "R5", i, act, m_d[i], cycles);
            end
            if (act >= modof(i)) begin
                errors++;
                $display("FAIL R6 digit %0d out of range: actual %0d expected <%0d", i, act, modof(i));
            end
        end
        if (dots_o != DOTS) begin
            errors++;
            $display("FAIL R8 dots: actual %b expected %b", dots_o, DOTS);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [4*N-1:0] snap;
        int before_roll;
        // R1: reset with a start pulse held; reset dominates.
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        check(digits_o == '0, "R1 reset clears", int'(digits_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: first digit change lands DIV edges after the run edge.
        start = 1'b1;
        @(negedge clk); start = 1'b0;          // run edge just passed
        repeat (DIV - 1) @(negedge clk);
        check(digits_o[3:0] == 4'd0, "R3 no tick before DIV", int'(digits_o[3:0]), 0);
        @(negedge clk);
        check(digits_o[3:0] == 4'd1, "R3 tick at DIV", int'(digits_o[3:0]), 1);

        // R4/R5/R6: run through 9->0 and 5->0 carries.
        repeat (200) @(negedge clk);

        // R2: pause and confirm the outputs freeze.
        pulse_start();
        snap = digits_o;
        repeat (40) @(negedge clk);
        check(digits_o == snap, "R2 frozen while paused", int'(digits_o), int'(snap));
        pulse_start();
        repeat (3 * DIV) @(negedge clk);
        check(digits_o != snap, "R2 resumes after start", int'(digits_o), int'(snap));

        // R7: run through two complete rollovers.
        before_roll = rollovers;
        while (rollovers < before_roll + 2) @(negedge clk);
        check(rollovers >= 2, "R7 rollover reached", rollovers, 2);
        repeat (DIV * 3) @(negedge clk);
        check(digits_o[3:0] != 4'd0 || digits_o != '0, "R7 keeps running",
              int'(digits_o), 1);

        // R1: mid-run reset clears everything and leaves the core paused.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(digits_o == '0, "R1 mid-run reset", int'(digits_o), 0);
        repeat (5 * DIV) @(negedge clk);
        check(digits_o == '0, "R1 paused after reset", int'(digits_o), 0);
        check(dots_o == DOTS, "R8 dots pass-through", int'(dots_o), int'(DOTS));

        finish_run();
    end
endmodule